// File: doc/BRIEF.md
# DMA peripheral request router

This block sits in front of one DMA channel and decides when a peripheral interrupt becomes a transfer trigger. A 4-bit select field chooses one of four peripheral lines: serial transmit-empty, serial receive-full, conversion-complete or timer compare-match. Each raw line is first ANDed with that peripheral's own interrupt-enable input. The selected line is synchronized and edge-detected. Each rising edge raises a request to the DMA engine, and the request stays up until the engine acknowledges it.

A request is only accepted while the channel and controller flags allow transfers. While a line is claimed as a trigger, its copy toward the CPU interrupt controller is masked, so the CPU never sees that interrupt. The block also checks the channel configuration against the chosen source. A 16-byte transfer size is not allowed in this mode, and some sources require a fixed data register as the source or destination endpoint. Any such mismatch raises a configuration-error output and blocks requests. The bus-mode choice (burst or cycle-steal) is passed straight through to the engine.

Top module: `dma_periph_req_router`

## Requirements
- R1: `sel_i` values 4'b1100, 4'b1101, 4'b1110 and 4'b1111 choose line index 0 (transmit-empty), 1 (receive-full), 2 (conversion-complete) and 3 (timer compare-match) of `irq_raw_i`/`irq_en_i`. Only the chosen line can cause a request.
- R2: A line counts as asserted only when both its `irq_raw_i` bit and its `irq_en_i` bit are 1. This applies to the trigger path and to `cpu_irq_o`.
- R3: A request is accepted only while `ch_en_i`=1, `mst_en_i`=1, `te_i`=0, `ae_i`=0 and `nmi_i`=0. If any of these fails, `dma_req_o` is 0 from the next clock onward, and an edge seen in that time is dropped.
- R4: In peripheral mode (`sel_i[3:2]`=2'b11), `size_i`=2'b11 (16-byte transfer) sets `cfg_err_o` and blocks all requests.
- R5: Endpoint codes are 0 for any, 1 for the transmit data register, 2 for the receive data register and 3 for the conversion result register. Index 0 needs `dst_ep_i`=1, index 1 needs `src_ep_i`=2 and index 2 needs `src_ep_i`=3. Index 3 has no constraint. A mismatch sets `cfg_err_o` and blocks requests.
- R6: Each rising edge of the qualified selected line sets `dma_req_o` on the third rising clock edge after the line changes. A line held high gives only one request.
- R7: `dma_req_o` stays 1 until a clock edge with `dma_ack_i`=1, and is 0 after that edge. If a new edge arrives on the same cycle as the acknowledge, the request stays set.
- R8: In peripheral mode, the selected line's `cpu_irq_o` bit is 0. Every other line's qualified value passes through.
- R9: With `sel_i[3:2]` other than 2'b11, all qualified lines pass to `cpu_irq_o`, `cfg_err_o` is 0 and no request is raised.
- R10: `burst_o` always equals `burst_i`.
- R11: After reset, `dma_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 4 | Resource-select field |
| size_i | input | 2 | Transfer size code, 2'b11 = 16 bytes |
| src_ep_i | input | 2 | Source endpoint code |
| dst_ep_i | input | 2 | Destination endpoint code |
| burst_i | input | 1 | Bus mode, 1 = burst, 0 = cycle-steal |
| ch_en_i | input | 1 | Channel enable |
| mst_en_i | input | 1 | Controller master enable |
| te_i | input | 1 | Transfer-end flag |
| ae_i | input | 1 | Address-error flag |
| nmi_i | input | 1 | NMI flag |
| irq_raw_i | input | 4 | Raw peripheral interrupt lines |
| irq_en_i | input | 4 | Per-peripheral interrupt enables |
| dma_ack_i | input | 1 | Engine acknowledge |
| dma_req_o | output | 1 | Transfer request to the engine |
| burst_o | output | 1 | Bus mode passed through |
| cfg_err_o | output | 1 | Illegal configuration |
| cpu_irq_o | output | 4 | Interrupt lines toward the CPU |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock as a new qualified rising edge. The bench gets there by timing both inputs exactly. It holds a pending request, drops the line, and raises it again. It then waits exactly two clocks so that the edge detector fires on the same edge where it drives `dma_ack_i`. The request must survive that edge. The bench also checks that dropping a single enable flag cancels a pending request one clock later.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  typedef enum logic [1:0] {
    EP_ANY = 2'd0,
    EP_TXD = 2'd1,
    EP_RXD = 2'd2,
    EP_ADC = 2'd3
  } endpoint_e;

  typedef enum logic [1:0] {
    SRC_TX_EMPTY = 2'd0,
    SRC_RX_FULL  = 2'd1,
    SRC_CONV_END = 2'd2,
    SRC_TIMER    = 2'd3
  } src_idx_e;

  localparam logic [1:0] SZ_16B = 2'b11;
endpackage

// File: rtl/dpr_src_mux.sv
module dpr_src_mux
  import dpr_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] irq_raw_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  output logic               periph_mode_o,
  output logic [IDX_W-1:0]   src_idx_o,
  output logic               trig_o,
  output logic [NUM_SRC-1:0] cpu_irq_o
);
  logic [NUM_SRC-1:0] gated;

  // upper select bits all ones -> peripheral request mode
  assign periph_mode_o = &sel_i[SEL_W-1:IDX_W];
  assign src_idx_o     = sel_i[IDX_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    assign gated[i]     = irq_raw_i[i] & irq_en_i[i];
    assign cpu_irq_o[i] = gated[i] & ~(periph_mode_o && (src_idx_o == IDX_W'(i)));
  end

  assign trig_o = periph_mode_o & gated[src_idx_o];

  // R8: claimed line never reaches the CPU
  a_r8_mask_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_mode_o |-> !cpu_irq_o[src_idx_o]);
  // R9: outside peripheral mode nothing triggers
  a_r9_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !periph_mode_o |-> !trig_o);
endmodule

// File: rtl/dpr_edge_sync.sv
module dpr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R6: a rising edge yields a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dpr_cfg_check.sv
module dpr_cfg_check
  import dpr_pkg::*;
(
  input  logic             periph_mode_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       src_ep_i,
  input  logic [1:0]       dst_ep_i,
  output logic             cfg_err_o
);
  logic ep_bad;

  always_comb begin
    unique case (src_idx_e'(src_idx_i))
      SRC_TX_EMPTY: ep_bad = (dst_ep_i != EP_TXD);
      SRC_RX_FULL:  ep_bad = (src_ep_i != EP_RXD);
      SRC_CONV_END: ep_bad = (src_ep_i != EP_ADC);
      default:      ep_bad = 1'b0;
    endcase
  end

  assign cfg_err_o = periph_mode_i & ((size_i == SZ_16B) | ep_bad);
endmodule

// File: rtl/dma_periph_req_router.sv
module dma_periph_req_router
  import dpr_pkg::*;
#(
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         src_ep_i,
  input  logic [1:0]         dst_ep_i,
  input  logic               burst_i,
  input  logic               ch_en_i,
  input  logic               mst_en_i,
  input  logic               te_i,
  input  logic               ae_i,
  input  logic               nmi_i,
  input  logic [NUM_SRC-1:0] irq_raw_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               dma_ack_i,
  output logic               dma_req_o,
  output logic               burst_o,
  output logic               cfg_err_o,
  output logic [NUM_SRC-1:0] cpu_irq_o
);
  logic             periph_mode;
  logic [IDX_W-1:0] src_idx;
  logic             trig;
  logic             rise;
  logic             qual;
  logic             pend_q;

  dpr_src_mux #(.SEL_W(SEL_W)) u_mux (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_i         (sel_i),
    .irq_raw_i     (irq_raw_i),
    .irq_en_i      (irq_en_i),
    .periph_mode_o (periph_mode),
    .src_idx_o     (src_idx),
    .trig_o        (trig),
    .cpu_irq_o     (cpu_irq_o)
  );

  dpr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (trig),
    .rise_o (rise)
  );

  dpr_cfg_check u_cfg (
    .periph_mode_i (periph_mode),
    .src_idx_i     (src_idx),
    .size_i        (size_i),
    .src_ep_i      (src_ep_i),
    .dst_ep_i      (dst_ep_i),
    .cfg_err_o     (cfg_err_o)
  );

  assign qual = periph_mode & ~cfg_err_o & ch_en_i & mst_en_i & ~te_i & ~ae_i & ~nmi_i;

  // new edge wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (rise && qual)    pend_q <= 1'b1;
    else if (!qual || dma_ack_i) pend_q <= 1'b0;
  end

  assign dma_req_o = pend_q;
  assign burst_o   = burst_i;

  a_r3_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> !dma_req_o);
  a_r4_cfg_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !dma_req_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dma_ack_i && qual) |=> dma_req_o);
  a_r7_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && !rise) |=> !dma_req_o);
  a_r6_req_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_req_o && !rise) |=> !dma_req_o);
endmodule

// File: tb/tb_dma_periph_req_router.sv
module tb_dma_periph_req_router;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel_i = 4'b0000;
  logic [1:0] size_i = 2'b00;
  logic [1:0] src_ep_i = 2'd0;
  logic [1:0] dst_ep_i = 2'd1;
  logic       burst_i = 1'b0;
  logic       ch_en_i = 1'b1, mst_en_i = 1'b1, te_i = 1'b0, ae_i = 1'b0, nmi_i = 1'b0;
  logic [3:0] irq_raw_i = 4'b0, irq_en_i = 4'b1111;
  logic       dma_ack_i = 1'b0;
  logic       dma_req_o, burst_o, cfg_err_o;
  logic [3:0] cpu_irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dma_periph_req_router dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clear_lines();
    irq_raw_i = 4'b0;
    cyc(4);
  endtask

  task automatic ack();
    dma_ack_i = 1'b1;
    cyc(1);
    dma_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset req", dma_req_o, 0);
    chk("R10 burst pass0", burst_o, 0);
    burst_i = 1'b1; #1;
    chk("R10 burst pass1", burst_o, 1);
  endtask

  task automatic t_sources();
    logic [1:0] src [4] = '{2'd0, 2'd2, 2'd3, 2'd0};
    logic [1:0] dst [4] = '{2'd1, 2'd0, 2'd0, 2'd0};
    for (int i = 0; i < 4; i++) begin
      sel_i = 4'b1100 | 4'(i); src_ep_i = src[i]; dst_ep_i = dst[i];
      cyc(1);
      chk("R5 legal cfg", cfg_err_o, 0);
      // wrong line does not trigger
      irq_raw_i = 4'b1111 & ~(4'b1 << i);
      cyc(4);
      chk("R1 other line ignored", dma_req_o, 0);
      chk("R8 others pass", cpu_irq_o, 4'b1111 & ~(4'b1 << i));
      irq_raw_i[i] = 1'b1;
      cyc(2);
      chk("R6 not yet", dma_req_o, 0);
      cyc(1);
      chk("R1 selected line req", dma_req_o, 1);
      chk("R8 claimed masked", cpu_irq_o[i], 0);
      cyc(5);
      chk("R7 held", dma_req_o, 1);
      ack();
      chk("R7 ack clears", dma_req_o, 0);
      cyc(5);
      chk("R6 one per edge", dma_req_o, 0);
      clear_lines();
    end
  endtask

  task automatic t_enable_bit();
    sel_i = 4'b1111; irq_en_i = 4'b0111;
    irq_raw_i = 4'b1111;
    cyc(4);
    chk("R2 disabled line no req", dma_req_o, 0);
    sel_i = 4'b0000; cyc(1);
    chk("R2 disabled line no cpu", cpu_irq_o, 4'b0111);
    irq_en_i = 4'b1111;
    clear_lines();
  endtask

  task automatic t_flags();
    sel_i = 4'b1111;
    for (int f = 0; f < 5; f++) begin
      ch_en_i = (f != 0); mst_en_i = (f != 1); te_i = (f == 2); ae_i = (f == 3); nmi_i = (f == 4);
      irq_raw_i[3] = 1'b1;
      cyc(4);
      chk("R3 flag blocks", dma_req_o, 0);
      ch_en_i = 1; mst_en_i = 1; te_i = 0; ae_i = 0; nmi_i = 0;
      clear_lines();
    end
    irq_raw_i[3] = 1'b1;
    cyc(3);
    chk("R3 req with flags ok", dma_req_o, 1);
    te_i = 1'b1;
    cyc(1);
    chk("R3 pending cancelled", dma_req_o, 0);
    te_i = 1'b0;
    cyc(3);
    chk("R3 no revival", dma_req_o, 0);
    clear_lines();
  endtask

  task automatic t_cfg();
    sel_i = 4'b1111; size_i = 2'b11;
    cyc(1);
    chk("R4 16B err", cfg_err_o, 1);
    irq_raw_i[3] = 1'b1;
    cyc(4);
    chk("R4 16B no req", dma_req_o, 0);
    chk("R8 masked under err", cpu_irq_o[3], 0);
    size_i = 2'b10;
    clear_lines();
    sel_i = 4'b1100; dst_ep_i = 2'd2; cyc(1);
    chk("R5 tx dst mismatch", cfg_err_o, 1);
    irq_raw_i[0] = 1'b1; cyc(4);
    chk("R5 mismatch no req", dma_req_o, 0);
    clear_lines();
    sel_i = 4'b1101; src_ep_i = 2'd3; cyc(1);
    chk("R5 rx src mismatch", cfg_err_o, 1);
    sel_i = 4'b1110; src_ep_i = 2'd2; cyc(1);
    chk("R5 conv src mismatch", cfg_err_o, 1);
    sel_i = 4'b1111; src_ep_i = 2'd1; dst_ep_i = 2'd3; cyc(1);
    chk("R5 timer any", cfg_err_o, 0);
    sel_i = 4'b0110; size_i = 2'b11; cyc(1);
    chk("R9 no err outside mode", cfg_err_o, 0);
    size_i = 2'b00;
  endtask

  task automatic t_off_mode();
    sel_i = 4'b1011;
    irq_raw_i = 4'b1010;
    cyc(4);
    chk("R9 no req", dma_req_o, 0);
    chk("R9 all pass", cpu_irq_o, 4'b1010);
    clear_lines();
  endtask

  task automatic t_ack_collide();
    sel_i = 4'b1111;
    irq_raw_i[3] = 1'b1; cyc(3);
    chk("R7 pending", dma_req_o, 1);
    irq_raw_i[3] = 1'b0; cyc(3);
    irq_raw_i[3] = 1'b1; cyc(2);
    // edge pulse high during the next posedge
    ack();
    chk("R7 edge beats ack", dma_req_o, 1);
    ack();
    chk("R7 later ack clears", dma_req_o, 0);
    clear_lines();
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_sources();
    t_enable_bit();
    t_flags();
    t_cfg();
    t_off_mode();
    t_ack_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule